// File: doc/BRIEF.md
# Three-Wire Serial Register Memory (Device Side)

This block is the device end of a three-wire serial memory holding 64 words of 16 bits. A host selects it with a chip-select line, shifts instructions in on a data-in line on rising edges of a serial clock, and receives read data or a ready/busy flag on a data-out line. Data out has a separate output enable, so the pad can be tri-stated. Every instruction is a start bit followed by an 8-bit field: a 2-bit opcode and a 6-bit word address. From this field the block decodes read, erase, write, erase-all, write-all, program-enable and program-disable.

Programming commands are guarded by an enable latch. They are armed by a complete frame and launched when chip select drops. Each one then runs for a fixed number of system clock cycles, set by a parameter. During that time the block steps through the addressed words of its storage one at a time, so the storage can map onto a single-port-write block RAM. While a program cycle is running, raising chip select shows the ready/busy state on data out.

All serial inputs are resynchronised to the system clock, and serial-clock rising edges are detected in that domain. The storage has no reset, so its contents survive a reset of the control logic.

Top module: `mw_eeprom`

## Requirements
- R1: A frame begins with the first serial-clock rise that samples data in at 1 while chip select is high; zeros sampled before that are ignored. The next 8 bits, MSB first, are the opcode (2 bits) and then the word address (6 bits).
- R2: Opcode 10 reads. After the last address bit, data out drives a 0 dummy bit. Each following serial-clock rise then moves data out to the next bit of the addressed word, D15 first and D0 last. Reads work whether programming is enabled or not.
- R3: Opcode 00 with address bits [5:4]=11 enables programming, and with [5:4]=00 disables it. Reset leaves programming disabled. While disabled, erase, write, erase-all and write-all change no word and start no program cycle.
- R4: Opcode 11 (erase) sets all 16 bits of the addressed word to 1 and leaves every other word unchanged.
- R5: Opcode 01 (write) is followed by 16 data bits, D15 first. The word becomes the old contents ANDed with the data, so a write can only clear bits.
- R6: Opcode 00 with [5:4]=10 (erase-all) sets every word to 0xFFFF.
- R7: Opcode 00 with [5:4]=01 (write-all) is followed by 16 data bits. Every word becomes its old contents ANDed with that pattern.
- R8: A program cycle starts only on the chip-select fall that follows a complete programming frame, and stays busy for PROG_CYCLES system clock cycles. A frame cut short by chip select going low has no effect.
- R9: Once a program cycle has started, chip select high with no new frame begun drives data out with 0 while busy and 1 when done.
- R10: Data out enable is low after reset, whenever chip select is low, and whenever neither read data nor status is being shown.
- R11: A start bit that arrives while a program cycle is running is ignored, together with the rest of that frame.
- R12: Word contents are kept through a reset of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the control logic |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sk_i | input | 1 | Serial clock from the host, asynchronous to clk |
| di_i | input | 1 | Serial data in, sampled on serial-clock rise |
| do_o | output | 1 | Serial data out: read bits or ready/busy flag |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
The assertions assume that each serial-clock phase and each chip-select low time last several system clocks longer than the synchroniser depth. They also assume that data in is stable around each serial-clock rise and that PROG_CYCLES exceeds the word count plus one. The bench keeps within these limits: it holds each serial-clock phase for eight system clocks, and it changes data in and chip select only while the serial clock is low. It waits out every chip-select low period, and it runs with a program time well above 65 cycles. It times its busy samples well inside the program window, so that a few cycles of synchroniser latency on either side do not move a result.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // opcode field (bits 7:6 of the 8-bit instruction field)
  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  // sub-codes carried in the top two address bits under OPC_EXT
  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_ARMED, ST_SKIP
  } frame_st_t;

  typedef enum logic {PG_ERASE, PG_WRITE} pg_kind_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // no reset: contents survive a control reset, and the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_prog.sv
module mw_prog
  import mw_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 64,
  parameter int PROG_CYCLES = 4000,
  localparam int AW         = $clog2(DEPTH),
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  pg_kind_t      kind,
  input  logic          all,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] pattern,
  output logic          busy,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] span;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(PROG_CYCLES - 1)) busy <= 1'b0;
    end
  end

  // read word k in step k, write it back in step k+1
  assign span  = all ? CW'(DEPTH) : CW'(1);
  assign raddr = all ? AW'(cnt) : addr;
  assign waddr = all ? AW'(cnt - CW'(1)) : addr;
  assign we    = busy && (cnt != '0) && (cnt <= span);
  assign wdata = (kind == PG_ERASE) ? {DW{1'b1}} : (pattern & rdata);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 64,
  parameter int PROG_CYCLES = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int IW  = 2 + AW;
  localparam int BCW = $clog2(DW + 1);

  logic cs_s, sk_s, di_s, cs_q, sk_q, sk_rise;
  frame_st_t st;
  logic [BCW-1:0] bit_cnt;
  logic [IW-1:0] ins_sr, ins_next;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] data_sr, out_sr, rdata, wdata;
  logic [1:0] opc, sub;
  logic wen, show_stat, start, busy, rd_act, pg_all, we;
  pg_kind_t pg_kind;
  logic [AW-1:0] pg_raddr, waddr, raddr;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({cs_i, sk_i, di_i}), .q({cs_s, sk_s, di_s}));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
    end
  end
  assign sk_rise  = sk_s && !sk_q;
  assign ins_next = {ins_sr[IW-2:0], di_s};
  assign opc      = ins_next[IW-1 -: 2];
  assign sub      = ins_next[AW-1 -: 2];
  assign rd_act   = (st == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      ins_sr    <= '0;
      cmd_addr  <= '0;
      data_sr   <= '0;
      out_sr    <= '0;
      wen       <= 1'b0;
      show_stat <= 1'b0;
      start     <= 1'b0;
      pg_kind   <= PG_ERASE;
      pg_all    <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!cs_s) begin
        if (st == ST_ARMED && cs_q && !busy) begin
          start     <= 1'b1;
          show_stat <= 1'b1;
        end
        st <= ST_IDLE;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (di_s && !busy) begin
            st        <= ST_CMD;
            bit_cnt   <= '0;
            show_stat <= 1'b0;
          end
          ST_CMD: begin
            ins_sr  <= ins_next;
            bit_cnt <= bit_cnt + BCW'(1);
            if (bit_cnt == BCW'(IW - 1)) begin
              bit_cnt  <= '0;
              cmd_addr <= ins_next[AW-1:0];
              pg_all   <= 1'b0;
              unique case (opc)
                OPC_READ:  st <= ST_READ;
                OPC_WRITE: begin pg_kind <= PG_WRITE; st <= wen ? ST_DATA : ST_SKIP; end
                OPC_ERASE: begin pg_kind <= PG_ERASE; st <= wen ? ST_ARMED : ST_SKIP; end
                default: begin
                  st <= ST_SKIP;
                  unique case (sub)
                    SUB_UNLOCK: wen <= 1'b1;
                    SUB_LOCK:   wen <= 1'b0;
                    SUB_WIPE: begin
                      pg_kind <= PG_ERASE; pg_all <= 1'b1;
                      st <= wen ? ST_ARMED : ST_SKIP;
                    end
                    default: begin
                      pg_kind <= PG_WRITE; pg_all <= 1'b1;
                      st <= wen ? ST_DATA : ST_SKIP;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            data_sr <= {data_sr[DW-2:0], di_s};
            bit_cnt <= bit_cnt + BCW'(1);
            if (bit_cnt == BCW'(DW - 1)) st <= ST_ARMED;
          end
          ST_READ: begin
            out_sr <= (bit_cnt == '0) ? rdata : {out_sr[DW-2:0], 1'b0};
            if (bit_cnt == BCW'(DW)) st <= ST_SKIP;
            else bit_cnt <= bit_cnt + BCW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // registered pad drive
  always_ff @(posedge clk) begin
    if (rst) begin
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else begin
      do_oe_o <= cs_s && (rd_act || (st == ST_IDLE && show_stat));
      do_o    <= rd_act ? ((bit_cnt != '0) && out_sr[DW-1]) : !busy;
    end
  end

  mw_prog #(.DW(DW), .DEPTH(DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start(start), .kind(pg_kind), .all(pg_all),
    .addr(cmd_addr), .pattern(data_sr), .busy(busy), .raddr(pg_raddr),
    .we(we), .waddr(waddr), .wdata(wdata), .rdata(rdata));

  assign raddr = busy ? pg_raddr : cmd_addr;

  mw_regfile #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata));
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 4000
) (
  input logic      clk,
  input logic      rst,
  input logic      cs_s,
  input logic      do_o,
  input logic      do_oe_o,
  input logic      busy,
  input logic      wen,
  input logic      rd_act,
  input frame_st_t st
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    do_oe_o |-> $past(cs_s)); // R10
  AST_PROG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen); // R3
  AST_PROG_AFTER_CS_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(cs_s)); // R8
  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_cnt == PROG_CYCLES); // R8
  AST_STATUS_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    (do_oe_o && !$past(rd_act) && $past(busy)) |-> !do_o); // R9
  AST_NO_FRAME_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD && $past(st) == ST_IDLE) |-> !$past(busy)); // R11
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .do_o(do_o), .do_oe_o(do_oe_o),
  .busy(busy), .wen(wen), .rd_act(rd_act), .st(st));

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int PC = 300;
  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_oe_o(do_oe));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(logic b); di = b; clks(8); sk = 1'b1; clks(8); sk = 1'b0; endtask
  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask
  task automatic fbegin(); cs = 1'b1; clks(4); endtask
  task automatic fend(); cs = 1'b0; di = 1'b0; clks(6); endtask
  task automatic instr(logic [1:0] op, logic [5:0] a); send({23'd0, 1'b1, op, a}, 9); endtask

  task automatic wait_ready();
    cs = 1'b1;
    for (int i = 0; i < PC + 60; i++) begin
      clks(1);
      if (do_oe && do_o) break;
    end
    fend();
  endtask

  task automatic read_reg(logic [5:0] a, int zeros, output logic [15:0] v);
    fbegin();
    if (zeros > 0) send(32'd0, zeros);
    instr(2'b10, a);
    chk(do_oe === 1'b1 && do_o === 1'b0, "R2 dummy bit", {14'd0, do_oe, do_o}, 16'h0002);
    for (int i = 15; i >= 0; i--) begin
      clks(8); sk = 1'b1; clks(8); sk = 1'b0;
      v[i] = do_o;
    end
    fend();
  endtask

  task automatic prog(logic [1:0] op, logic [5:0] a, bit has_data, logic [15:0] d);
    fbegin();
    instr(op, a);
    if (has_data) send({16'd0, d}, 16);
    fend();
  endtask

  task automatic expect_reg(logic [5:0] a, logic [15:0] exp, string req);
    logic [15:0] v;
    read_reg(a, 0, v);
    chk(v === exp, req, v, exp);
  endtask

  task automatic t_reset();
    cs = 1'b1; clks(6);
    chk(do_oe === 1'b0, "R10 oe low after reset", {15'd0, do_oe}, 16'h0000);
    cs = 1'b0; clks(4);
  endtask

  task automatic t_locked_after_reset();
    prog(2'b00, 6'b100000, 1'b0, 16'h0);
    cs = 1'b1; clks(10);
    chk(do_oe === 1'b0, "R3 erase-all while disabled starts nothing", {15'd0, do_oe}, 16'h0000);
    cs = 1'b0; clks(4);
  endtask

  task automatic t_erase_all();
    prog(2'b00, 6'b110000, 1'b0, 16'h0);
    prog(2'b00, 6'b100000, 1'b0, 16'h0);
    cs = 1'b1; clks(10);
    chk(do_oe === 1'b1 && do_o === 1'b0, "R9 busy shows 0", {14'd0, do_oe, do_o}, 16'h0002);
    clks(PC - 50);
    chk(do_o === 1'b0, "R8 still busy near end", {15'd0, do_o}, 16'h0000);
    clks(60);
    chk(do_oe === 1'b1 && do_o === 1'b1, "R9 ready shows 1", {14'd0, do_oe, do_o}, 16'h0003);
    fend();
    expect_reg(6'd0, 16'hFFFF, "R6 word 0");
    expect_reg(6'd37, 16'hFFFF, "R6 word 37");
    expect_reg(6'd63, 16'hFFFF, "R6 word 63");
  endtask

  task automatic t_write_and();
    prog(2'b01, 6'd5, 1'b1, 16'h1234); wait_ready();
    expect_reg(6'd5, 16'h1234, "R5 write");
    expect_reg(6'd4, 16'hFFFF, "R5 neighbour untouched");
    prog(2'b01, 6'd5, 1'b1, 16'hFF00); wait_ready();
    expect_reg(6'd5, 16'h1200, "R5 write ANDs old contents");
  endtask

  task automatic t_disable();
    prog(2'b00, 6'b000000, 1'b0, 16'h0);
    prog(2'b11, 6'd5, 1'b0, 16'h0); clks(PC + 20);
    expect_reg(6'd5, 16'h1200, "R3 erase ignored when disabled, R2 read while disabled");
  endtask

  task automatic t_reset_keep();
    rst = 1'b1; clks(4); rst = 1'b0; clks(4);
    expect_reg(6'd5, 16'h1200, "R12 contents kept over reset");
    prog(2'b11, 6'd5, 1'b0, 16'h0); clks(PC + 20);
    expect_reg(6'd5, 16'h1200, "R3 disabled after reset");
  endtask

  task automatic t_erase_one();
    prog(2'b00, 6'b110000, 1'b0, 16'h0);
    prog(2'b01, 6'd6, 1'b1, 16'h00F0); wait_ready();
    prog(2'b11, 6'd5, 1'b0, 16'h0); wait_ready();
    expect_reg(6'd5, 16'hFFFF, "R4 erase addressed word");
    expect_reg(6'd6, 16'h00F0, "R4 other word untouched");
  endtask

  task automatic t_abort();
    fbegin();
    instr(2'b01, 6'd7);
    send(32'h0, 8);
    fend();
    clks(PC + 20);
    expect_reg(6'd7, 16'hFFFF, "R8 aborted frame has no effect");
  endtask

  task automatic t_busy_ignore();
    prog(2'b01, 6'd8, 1'b1, 16'h0000);
    chk(do_oe === 1'b0, "R10 oe low with cs low", {15'd0, do_oe}, 16'h0000);
    fbegin();
    instr(2'b11, 6'd6);
    fend();
    wait_ready();
    expect_reg(6'd6, 16'h00F0, "R11 erase during busy ignored");
    expect_reg(6'd8, 16'h0000, "R5 write of zero");
  endtask

  task automatic t_leading_zero();
    logic [15:0] v;
    read_reg(6'd6, 3, v);
    chk(v === 16'h00F0, "R1 leading zeros before start bit", v, 16'h00F0);
  endtask

  task automatic t_write_all();
    prog(2'b00, 6'b100000, 1'b0, 16'h0); wait_ready();
    prog(2'b00, 6'b010000, 1'b1, 16'hA5C3); wait_ready();
    expect_reg(6'd0, 16'hA5C3, "R7 write-all word 0");
    expect_reg(6'd63, 16'hA5C3, "R7 write-all word 63");
    prog(2'b00, 6'b010000, 1'b1, 16'h0FF0); wait_ready();
    expect_reg(6'd10, 16'h05C0, "R7 write-all ANDs old contents");
  endtask

  initial begin
    clks(5); rst = 1'b0; clks(5);
    t_reset();
    t_locked_after_reset();
    t_erase_all();
    t_write_and();
    t_disable();
    t_reset_keep();
    t_erase_one();
    t_abort();
    t_busy_ignore();
    t_leading_zero();
    t_write_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule